// File: doc/BRIEF.md
# System Reset Sequencer

This block combines four reset requests into one system reset. The requests are power-on, an active-low external pin, brown-out and a watchdog timeout. It keeps the processor core halted until a timed release sequence has finished. The length of that sequence depends on which source caused the reset, and the source of the most recent reset is kept in a cause register that software can read after start-up.

Power-on is an asynchronous, level-high request that also resets the block's own state. Brown-out is a comparator level, and it counts only while the enable input is high. The external pin passes through a synchronizer and must stay low for a minimum number of clock cycles before it is taken as a reset. While a qualified pin stays low, the block asks the oscillator and analog circuits to enter low power. Brown-out and pin resets hold the system in reset while their condition lasts, and the timed release starts only once the condition clears. The watchdog pulse starts the timed release at once.

While the reset is active, the block also forces I/O to tri-state and strobes default loading into the register file. It tells the data memory whether its contents survive, which they do not after power-on.

Top module: `reset_sequencer`

## Requirements
- R1: While `porReq` is high, `coreHalt`, `ioTristate` and `loadDefaults` are 1 and `rstCause` is 0 (power-on). After `porReq` falls, `coreHalt` stays high for exactly POR_LEN clock cycles.
- R2: A one-cycle `wdtPulse` while running sets `rstCause` to 3 (watchdog) and halts the core for exactly WDT_LEN cycles.
- R3: With `borEn` high, a high `borDet` holds the core halted for as long as it stays high. After it falls, the core stays halted for SYNC_STAGES + BOR_LEN cycles, and `rstCause` is 1 (brown-out).
- R4: With `borEn` low, `borDet` has no effect: the core is never halted and `rstCause` keeps its value.
- R5: An `extRstN` low time of at least EXT_MIN_LOW cycles is a reset. While the pin stays low, `coreHalt` and `lowPower` are 1. After the rising edge, the core stays halted for SYNC_STAGES + EXT_LEN cycles, and `rstCause` is 2 (external).
- R6: An `extRstN` low pulse shorter than EXT_MIN_LOW cycles is ignored: no halt, and `rstCause` is unchanged.
- R7: A new request during a running sequence restarts the sequence with the length that belongs to that request.
- R8: When requests coincide, brown-out wins over external, and external wins over watchdog.
- R9: `loadDefaults` is high in every cycle of a held reset, for exactly one cycle when a watchdog sequence starts, and low while running.
- R10: `dataKeep` is 0 after a power-on reset and 1 after any other cause.
- R11: `rstCause` does not change while the core runs.
- R12: `ioTristate` is high in exactly those cycles in which `coreHalt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porReq | input | 1 | Power-on request, asynchronous, high while the supply is not good |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| borDet | input | 1 | Brown-out comparator output, high while the supply is low |
| borEn | input | 1 | Brown-out reset enable |
| wdtPulse | input | 1 | One-cycle watchdog timeout |
| coreHalt | output | 1 | Holds instruction execution stopped |
| ioTristate | output | 1 | Forces all I/O to tri-state input |
| lowPower | output | 1 | Low-power request to the oscillator and analog circuits |
| loadDefaults | output | 1 | Register file loads its default values |
| dataKeep | output | 1 | Data memory contents are valid after this reset |
| rstCause | output | 2 | Source of the last reset: 0 power-on, 1 brown-out, 2 external, 3 watchdog |

## Verification
The watchdog pulse and the synchronized brown-out level can reach the controller on the same clock edge. This puts the priority logic and the sequence-start logic into one cycle. The bench raises `borDet` two cycles before it drives `wdtPulse`, so that both arrive together. It then judges that the cause is brown-out, that the reset is still held while `borDet` stays high, and that the release takes the brown-out length rather than the watchdog length. A second case lands the watchdog pulse while a qualified pin hold is active, and expects the external cause.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  typedef enum logic [1:0] {
    CAUSE_POR = 2'd0,
    CAUSE_BOR = 2'd1,
    CAUSE_EXT = 2'd2,
    CAUSE_WDT = 2'd3
  } rstCause_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_COUNT = 2'd2
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic      seqLoad;
    logic      seqRun;
    rstCause_e loadSrc;
  } seqCmd_t;

endpackage

// File: rtl/reset_seq_dp.sv
module reset_seq_dp
  import reset_seq_pkg::*;
#(
  parameter int POR_LEN     = 40,
  parameter int BOR_LEN     = 24,
  parameter int EXT_LEN     = 16,
  parameter int WDT_LEN     = 8,
  parameter int EXT_MIN_LOW = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      porReq,
  input  logic      extRstN,
  input  logic      borDet,
  input  seqCmd_t   cmd,
  output logic      borSync,
  output logic      extQual,
  output logic      seqZero,
  output logic      dataKeep,
  output rstCause_e rstCause
);

  localparam int MAX_AB  = (POR_LEN > BOR_LEN) ? POR_LEN : BOR_LEN;
  localparam int MAX_CD  = (EXT_LEN > WDT_LEN) ? EXT_LEN : WDT_LEN;
  localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int SEQ_W   = $clog2(MAX_LEN + 1);
  localparam int LOW_W   = $clog2(EXT_MIN_LOW + 1);
  localparam int SYNC_N  = 2;
  // bit 0: pin (idles high), bit 1: brown-out (idles low)
  localparam logic [SYNC_N-1:0] SYNC_INIT = 2'b01;

  logic [SYNC_N-1:0] rawIn;
  logic [SYNC_N-1:0] syncOut;
  logic              extSync;
  logic [SEQ_W-1:0]  seqCnt;
  logic [LOW_W-1:0]  lowCnt;
  rstCause_e         causeReg;

  assign rawIn = {borDet, extRstN};

  for (genvar g = 0; g < SYNC_N; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or posedge porReq) begin
      if (porReq) chain <= {SYNC_STAGES{SYNC_INIT[g]}};
      else        chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  assign extSync = syncOut[0];
  assign borSync = syncOut[1];

  function automatic logic [SEQ_W-1:0] lenOf(input rstCause_e src);
    case (src)
      CAUSE_POR: lenOf = SEQ_W'(POR_LEN - 1);
      CAUSE_BOR: lenOf = SEQ_W'(BOR_LEN - 1);
      CAUSE_EXT: lenOf = SEQ_W'(EXT_LEN - 1);
      default:   lenOf = SEQ_W'(WDT_LEN - 1);
    endcase
  endfunction

  // pin low-time qualification
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)                            lowCnt <= '0;
    else if (extSync)                      lowCnt <= '0;
    else if (lowCnt != LOW_W'(EXT_MIN_LOW)) lowCnt <= lowCnt + 1'b1;
  end

  assign extQual = !extSync && (lowCnt >= LOW_W'(EXT_MIN_LOW - 1));

  // release counter and cause register
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      seqCnt   <= lenOf(CAUSE_POR);
      causeReg <= CAUSE_POR;
    end else if (cmd.seqLoad) begin
      seqCnt   <= lenOf(cmd.loadSrc);
      causeReg <= cmd.loadSrc;
    end else if (cmd.seqRun && seqCnt != '0) begin
      seqCnt   <= seqCnt - 1'b1;
    end
  end

  assign seqZero  = (seqCnt == '0);
  assign rstCause = causeReg;
  assign dataKeep = (causeReg != CAUSE_POR);

endmodule

// File: rtl/reset_seq_ctrl.sv
module reset_seq_ctrl
  import reset_seq_pkg::*;
(
  input  logic      clk,
  input  logic      porReq,
  input  logic      borEn,
  input  logic      borSync,
  input  logic      extQual,
  input  logic      wdtPulse,
  input  logic      seqZero,
  input  rstCause_e rstCause,
  output seqCmd_t   cmd,
  output logic      coreHalt,
  output logic      ioTristate,
  output logic      lowPower,
  output logic      loadDefaults
);

  seqState_e state, nextState;
  logic      ldReg;

  always_comb begin
    nextState   = state;
    cmd         = '0;
    cmd.loadSrc = CAUSE_WDT;
    if (borEn && borSync) begin
      nextState   = ST_HOLD;
      cmd.seqLoad = 1'b1;
      cmd.loadSrc = CAUSE_BOR;
    end else if (extQual) begin
      nextState   = ST_HOLD;
      cmd.seqLoad = 1'b1;
      cmd.loadSrc = CAUSE_EXT;
    end else if (wdtPulse) begin
      nextState   = ST_COUNT;
      cmd.seqLoad = 1'b1;
      cmd.loadSrc = CAUSE_WDT;
    end else begin
      case (state)
        ST_HOLD:  nextState = ST_COUNT;
        ST_COUNT: begin
          cmd.seqRun = 1'b1;
          if (seqZero) nextState = ST_RUN;
        end
        default:  nextState = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      state <= ST_HOLD;
      ldReg <= 1'b1;
    end else begin
      state <= nextState;
      ldReg <= cmd.seqLoad;
    end
  end

  assign coreHalt     = (state != ST_RUN);
  assign ioTristate   = (state != ST_RUN);
  assign lowPower     = (state == ST_HOLD) && (rstCause == CAUSE_EXT);
  assign loadDefaults = ldReg;

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_seq_pkg::*;
#(
  parameter int POR_LEN     = 40,
  parameter int BOR_LEN     = 24,
  parameter int EXT_LEN     = 16,
  parameter int WDT_LEN     = 8,
  parameter int EXT_MIN_LOW = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       extRstN,
  input  logic       borDet,
  input  logic       borEn,
  input  logic       wdtPulse,
  output logic       coreHalt,
  output logic       ioTristate,
  output logic       lowPower,
  output logic       loadDefaults,
  output logic       dataKeep,
  output logic [1:0] rstCause
);

  seqCmd_t   cmd;
  logic      borSync, extQual, seqZero;
  rstCause_e causeSig;

  reset_seq_dp #(
    .POR_LEN(POR_LEN), .BOR_LEN(BOR_LEN), .EXT_LEN(EXT_LEN),
    .WDT_LEN(WDT_LEN), .EXT_MIN_LOW(EXT_MIN_LOW), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .porReq(porReq), .extRstN(extRstN), .borDet(borDet),
    .cmd(cmd), .borSync(borSync), .extQual(extQual), .seqZero(seqZero),
    .dataKeep(dataKeep), .rstCause(causeSig)
  );

  reset_seq_ctrl u_ctrl (
    .clk(clk), .porReq(porReq), .borEn(borEn), .borSync(borSync),
    .extQual(extQual), .wdtPulse(wdtPulse), .seqZero(seqZero),
    .rstCause(causeSig), .cmd(cmd), .coreHalt(coreHalt),
    .ioTristate(ioTristate), .lowPower(lowPower), .loadDefaults(loadDefaults)
  );

  assign rstCause = causeSig;

endmodule

// File: rtl/reset_seq_chk.sv
module reset_seq_chk (
  input logic       clk,
  input logic       porReq,
  input logic       wdtPulse,
  input logic       coreHalt,
  input logic       lowPower,
  input logic       loadDefaults,
  input logic [1:0] rstCause
);

  // R5
  lowpower_halted_chk: assert property (@(posedge clk) disable iff (porReq)
    lowPower |-> coreHalt);

  // R2
  wdt_halts_chk: assert property (@(posedge clk) disable iff (porReq)
    wdtPulse |=> coreHalt);

  // R11
  cause_stable_chk: assert property (@(posedge clk) disable iff (porReq)
    (!coreHalt && !$past(coreHalt)) |-> $stable(rstCause));

  // R9
  halt_start_load_chk: assert property (@(posedge clk) disable iff (porReq)
    $rose(coreHalt) |-> loadDefaults);

  // R9
  run_no_load_chk: assert property (@(posedge clk) disable iff (porReq)
    $fell(coreHalt) |-> !loadDefaults);

endmodule

bind reset_sequencer reset_seq_chk u_chk (
  .clk(clk), .porReq(porReq), .wdtPulse(wdtPulse), .coreHalt(coreHalt),
  .lowPower(lowPower), .loadDefaults(loadDefaults), .rstCause(rstCause)
);

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;

  localparam int POR_LEN = 40, BOR_LEN = 24, EXT_LEN = 16, WDT_LEN = 8;
  localparam int EXT_MIN_LOW = 20, SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic porReq = 1'b1, extRstN = 1'b1, borDet = 1'b0, borEn = 1'b0, wdtPulse = 1'b0;
  logic coreHalt, ioTristate, lowPower, loadDefaults, dataKeep;
  logic [1:0] rstCause;
  int checks = 0, bad = 0;

  always #2 clk = ~clk;

  reset_sequencer u_reset_sequencer (
    .clk(clk), .porReq(porReq), .extRstN(extRstN), .borDet(borDet),
    .borEn(borEn), .wdtPulse(wdtPulse), .coreHalt(coreHalt),
    .ioTristate(ioTristate), .lowPower(lowPower), .loadDefaults(loadDefaults),
    .dataKeep(dataKeep), .rstCause(rstCause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // samples from the current negedge on; returns halted cycle count
  task automatic measureHalt(output int n, output int ld, output int mis);
    n = 0; ld = 0; mis = 0;
    for (int i = 0; i < 2000; i++) begin
      if (ioTristate !== coreHalt) mis++;
      if (!coreHalt) break;
      n++;
      if (loadDefaults) ld++;
      @(negedge clk);
    end
  endtask

  task automatic watchNoHalt(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (coreHalt) seen++;
    end
  endtask

  task automatic testPowerOn();
    int n, ld, mis;
    repeat (3) @(negedge clk);
    chk("R1 halt in reset", coreHalt, 1);
    chk("R1 load in reset", loadDefaults, 1);
    chk("R1 cause in reset", rstCause, 0);
    chk("R12 tristate in reset", ioTristate, 1);
    chk("R10 no keep after power-on", dataKeep, 0);
    porReq = 1'b0;
    @(negedge clk);
    measureHalt(n, ld, mis);
    chk("R1 power-on release length", n, POR_LEN);
    chk("R12 tristate tracks halt", mis, 0);
  endtask

  task automatic testWatchdog();
    int n, ld, mis;
    wdtPulse = 1'b1;
    @(negedge clk);
    wdtPulse = 1'b0;
    measureHalt(n, ld, mis);
    chk("R2 watchdog length", n, WDT_LEN);
    chk("R2 watchdog cause", rstCause, 3);
    chk("R9 single load strobe", ld, 1);
    chk("R10 keep after watchdog", dataKeep, 1);
    chk("R9 no load while running", loadDefaults, 0);
  endtask

  task automatic testBorDisabled();
    int seen;
    borEn = 1'b0;
    borDet = 1'b1;
    watchNoHalt(30, seen);
    borDet = 1'b0;
    chk("R4 disabled brown-out no halt", seen, 0);
    chk("R4 cause unchanged", rstCause, 3);
  endtask

  task automatic testBorEnabled();
    int n, ld, mis;
    borEn = 1'b1;
    borDet = 1'b1;
    repeat (20) @(negedge clk);
    chk("R3 held during brown-out", coreHalt, 1);
    chk("R9 load during hold", loadDefaults, 1);
    borDet = 1'b0;
    @(negedge clk);
    measureHalt(n, ld, mis);
    chk("R3 brown-out release length", n, SYNC_STAGES + BOR_LEN);
    chk("R3 brown-out cause", rstCause, 1);
    chk("R12 tristate tracks halt", mis, 0);
  endtask

  task automatic testExtShort();
    int seen, s2;
    extRstN = 1'b0;
    repeat (EXT_MIN_LOW - 2) @(negedge clk);
    extRstN = 1'b1;
    watchNoHalt(10, seen);
    chk("R6 short pin pulse ignored", seen, 0);
    chk("R6 cause unchanged", rstCause, 1);
    s2 = 0;
  endtask

  task automatic testExtLong();
    int n, ld, mis;
    extRstN = 1'b0;
    repeat (EXT_MIN_LOW + 10) @(negedge clk);
    chk("R5 held during pin low", coreHalt, 1);
    chk("R5 low power during pin low", lowPower, 1);
    extRstN = 1'b1;
    @(negedge clk);
    measureHalt(n, ld, mis);
    chk("R5 pin release length", n, SYNC_STAGES + EXT_LEN);
    chk("R5 pin cause", rstCause, 2);
    chk("R5 low power off after release", lowPower, 0);
  endtask

  task automatic testRestart();
    int n, ld, mis;
    wdtPulse = 1'b1;
    @(negedge clk);
    wdtPulse = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wdtPulse = 1'b1;
    @(negedge clk);
    wdtPulse = 1'b0;
    measureHalt(n, ld, mis);
    chk("R7 restart total length", n + 3, 3 + WDT_LEN);
  endtask

  task automatic testPriorityBorWdt();
    int n, ld, mis;
    borEn = 1'b1;
    borDet = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wdtPulse = 1'b1;
    @(negedge clk);
    wdtPulse = 1'b0;
    chk("R8 brown-out beats watchdog", rstCause, 1);
    repeat (5) @(negedge clk);
    chk("R8 still held by brown-out", coreHalt, 1);
    borDet = 1'b0;
    @(negedge clk);
    measureHalt(n, ld, mis);
    chk("R8 brown-out length after tie", n, SYNC_STAGES + BOR_LEN);
  endtask

  task automatic testPriorityExtWdt();
    int n, ld, mis;
    extRstN = 1'b0;
    repeat (EXT_MIN_LOW + 5) @(negedge clk);
    wdtPulse = 1'b1;
    @(negedge clk);
    wdtPulse = 1'b0;
    @(negedge clk);
    chk("R8 pin beats watchdog", rstCause, 2);
    extRstN = 1'b1;
    @(negedge clk);
    measureHalt(n, ld, mis);
    chk("R8 pin length after tie", n, SYNC_STAGES + EXT_LEN);
  endtask

  initial begin
    testPowerOn();
    testWatchdog();
    testBorDisabled();
    testBorEnabled();
    testExtShort();
    testExtLong();
    testRestart();
    testPriorityBorWdt();
    testPriorityExtWdt();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    bad++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule